// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a bus-attached watchdog that counts in two chained stages. A free-running prescaler turns the bus clock into ticks. After software enables it, the block counts the first stage and, when that stage runs out, latches a status flag and raises a pre-timeout interrupt level. The second stage then begins. When it runs out, the block latches a second flag and fires a one-cycle pulse on one of three reset outputs, chosen by a mode field.

Software keeps the watchdog alive by writing a kick value during the first stage, which restarts that stage from zero. The first stage can also be cancelled by clearing the enable bit. Once the first stage has expired, both disabling and kicking are ignored, so the reset at the end of the second stage cannot be avoided. Status flags are cleared by writing ones. The reset and interrupt fabric outside the block is modelled only as the output pins.

Top module: `two_phase_wdt`

## Requirements
- R1: After reset the control register (offset 0x8) reads 0x00000001, the status register (offset 0x4) reads 0, and irq_o, rst_chip_o, rst_cpu_o and rst_sw_o are all low.
- R2: One tick lasts 2^(BASE_LOG2+S) clock cycles, where S is control bits 30:29.
- R3: A control write with bit 31 = 1 while idle starts the first stage. The first stage lasts (A+1) ticks, where A is control bits 26:22. The clock edge that ends it sets status bit 31, and irq_o is high from that edge on.
- R4: The second stage starts at once and lasts (B+1) ticks, where B is control bits 19:15. The clock edge that ends it sets status bit 30 and registers a reset pulse.
- R5: Control bits 1:0 choose the reset output: 0 or 3 pulses rst_chip_o, 1 pulses rst_cpu_o, and 2 pulses rst_sw_o. Exactly one output is high, for exactly one clock cycle.
- R6: After the pulse the block is idle. Control bit 31 reads 0, the other control fields keep their values, and no further interrupt or pulse occurs.
- R7: A write to offset 0x0 with bit 31 = 1 during the first stage restarts that stage, with the prescaler and tick count at zero. A write there with bit 31 = 0 has no effect, and so does any kick write while idle.
- R8: A control write with bit 31 = 0 during the first stage stops the count with no interrupt. A later write with bit 31 = 1 starts a fresh first stage.
- R9: During the second stage, neither clearing enable nor kicking changes the cycle on which the reset pulse occurs.
- R10: Status bits 31 and 30 are write-one-to-clear, and writing 0 to a bit leaves it unchanged. irq_o equals status bit 31.
- R11: rdata_o holds the value of the register at addr_i from the clock edge that samples re_i. Offset 0x0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | bus clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| addr_i | input | ADDR_W | register byte offset |
| wdata_i | input | 32 | write data |
| we_i | input | 1 | write strobe |
| re_i | input | 1 | read strobe |
| rdata_o | output | 32 | registered read data |
| irq_o | output | 1 | pre-timeout interrupt level |
| rst_chip_o | output | 1 | whole-chip reset pulse |
| rst_cpu_o | output | 1 | processor-only reset pulse |
| rst_sw_o | output | 1 | software-level reset pulse |

## Verification
A wrong stage count, prescale or restart point appears at the ports as an interrupt edge or reset pulse on the wrong cycle, so the bench predicts the exact cycle of each event and compares. An error in the lock-out or in the idle return appears either as a missing pulse after a late disable or kick, or as a spurious event during a long quiet window. Status and control corruption appears in the registered read data on the cycle after the read strobe.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PS_W    = 2;
  localparam int PHASE_W = 5;
  localparam int MODE_W  = 2;
  localparam int RST_N   = 3;

  localparam int OFS_KICK = 'h0;
  localparam int OFS_STAT = 'h4;
  localparam int OFS_CTRL = 'h8;

  localparam int BIT_EN   = 31;
  localparam int BIT_PS   = 29;
  localparam int BIT_P1   = 22;
  localparam int BIT_P2   = 15;
  localparam int BIT_MODE = 0;
  localparam int BIT_ST1  = 31;
  localparam int BIT_ST2  = 30;

  typedef enum logic [1:0] {PH_IDLE, PH_ONE, PH_TWO} phase_e;

  typedef struct packed {
    logic               en;
    logic [PS_W-1:0]    ps;
    logic [PHASE_W-1:0] p1;
    logic [PHASE_W-1:0] p2;
    logic [MODE_W-1:0]  mode;
  } ctrl_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int BASE_LOG2 = 25,
  parameter int PS_W      = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            clr_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            tick_o
);
  localparam int CNT_W = BASE_LOG2 + (2**PS_W) - 1;
  localparam int SH_W  = $clog2(CNT_W);

  logic [CNT_W-1:0] cnt_q, lim;
  logic [SH_W-1:0]  sh;

  assign sh     = SH_W'(BASE_LOG2) + SH_W'(ps_i);
  assign lim    = (CNT_W'(1) << sh) - CNT_W'(1);
  assign tick_o = run_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i || !run_i || tick_o) cnt_q <= '0;
    else                           cnt_q <= cnt_q + CNT_W'(1);
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdt_phase_ctrl.sv
module wdt_phase_ctrl
  import wdt_pkg::*;
#(
  parameter int PW = PHASE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              kick_i,
  input  logic [PW-1:0]     p1_i,
  input  logic [PW-1:0]     p2_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              run_o,
  output logic              clr_o,
  output logic              ph1_exp_o,
  output logic              ph2_exp_o,
  output logic [RST_N-1:0]  rst_o
);
  phase_e        state_q;
  logic [PW-1:0] tc_q, lim;
  logic          hit;
  logic [RST_N-1:0] sel, rst_q;

  assign lim       = (state_q == PH_ONE) ? p1_i : p2_i;
  assign hit       = tick_i && (tc_q >= lim);
  assign run_o     = (state_q != PH_IDLE);
  assign clr_o     = ((state_q == PH_IDLE) && start_i) || ((state_q == PH_ONE) && kick_i);
  assign ph1_exp_o = (state_q == PH_ONE) && hit && !stop_i && !kick_i;
  assign ph2_exp_o = (state_q == PH_TWO) && hit;

  always_comb begin
    sel = '0;
    unique case (mode_i)
      2'd1:    sel[1] = 1'b1;
      2'd2:    sel[2] = 1'b1;
      default: sel[0] = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      tc_q    <= '0;
      rst_q   <= '0;
    end else begin
      rst_q <= ph2_exp_o ? sel : '0;
      unique case (state_q)
        PH_IDLE: if (start_i) begin state_q <= PH_ONE; tc_q <= '0; end
        PH_ONE: begin
          if (stop_i)      begin state_q <= PH_IDLE; tc_q <= '0; end
          else if (kick_i) tc_q <= '0;
          else if (hit)    begin state_q <= PH_TWO; tc_q <= '0; end
          else if (tick_i) tc_q <= tc_q + PW'(1);
        end
        PH_TWO: begin
          if (hit)         begin state_q <= PH_IDLE; tc_q <= '0; end
          else if (tick_i) tc_q <= tc_q + PW'(1);
        end
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  assign rst_o = rst_q;

  // R5
  rst_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rst_q));
  // R5
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rst_q) |=> !(|rst_q));
  // R9
  leave_two_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_IDLE && $past(state_q) == PH_TWO) |-> ($countones(rst_q) == 1));
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              ph1_exp_i,
  input  logic              ph2_exp_i,
  output logic [31:0]       rdata_o,
  output ctrl_t             ctrl_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              kick_o,
  output logic              irq_o
);
  ctrl_t       ctrl_q;
  logic        st1_q, st2_q;
  logic        wr_ctrl, wr_stat;
  logic [31:0] rd;

  assign wr_ctrl = we_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign wr_stat = we_i && (addr_i == ADDR_W'(OFS_STAT));
  assign kick_o  = we_i && (addr_i == ADDR_W'(OFS_KICK)) && wdata_i[BIT_EN];
  assign start_o = wr_ctrl && wdata_i[BIT_EN];
  assign stop_o  = wr_ctrl && !wdata_i[BIT_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '{en: 1'b0, ps: '0, p1: '0, p2: '0, mode: MODE_W'(1)};
      st1_q  <= 1'b0;
      st2_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en   <= wdata_i[BIT_EN];
        ctrl_q.ps   <= wdata_i[BIT_PS +: PS_W];
        ctrl_q.p1   <= wdata_i[BIT_P1 +: PHASE_W];
        ctrl_q.p2   <= wdata_i[BIT_P2 +: PHASE_W];
        ctrl_q.mode <= wdata_i[BIT_MODE +: MODE_W];
      end
      if (ph2_exp_i) ctrl_q.en <= 1'b0;
      st1_q <= ph1_exp_i || (st1_q && !(wr_stat && wdata_i[BIT_ST1]));
      st2_q <= ph2_exp_i || (st2_q && !(wr_stat && wdata_i[BIT_ST2]));
    end
  end

  always_comb begin
    rd = '0;
    if (addr_i == ADDR_W'(OFS_CTRL)) begin
      rd[BIT_EN]              = ctrl_q.en;
      rd[BIT_PS +: PS_W]      = ctrl_q.ps;
      rd[BIT_P1 +: PHASE_W]   = ctrl_q.p1;
      rd[BIT_P2 +: PHASE_W]   = ctrl_q.p2;
      rd[BIT_MODE +: MODE_W]  = ctrl_q.mode;
    end else if (addr_i == ADDR_W'(OFS_STAT)) begin
      rd[BIT_ST1] = st1_q;
      rd[BIT_ST2] = st2_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd;
  end

  assign ctrl_o = ctrl_q;
  assign irq_o  = st1_q;

  // R3
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph1_exp_i |=> irq_o);
  // R6
  en_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph2_exp_i |=> !ctrl_q.en);
  // R10
  st_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st2_q && !(wr_stat && wdata_i[BIT_ST2])) |=> st2_q);
endmodule

// File: rtl/two_phase_wdt.sv
module two_phase_wdt
  import wdt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int BASE_LOG2 = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              rst_chip_o,
  output logic              rst_cpu_o,
  output logic              rst_sw_o
);
  ctrl_t            ctrl;
  logic             start, stop, kick, run, clr, tick, ph1_exp, ph2_exp;
  logic [RST_N-1:0] rst_vec;

  wdt_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .re_i,
    .ph1_exp_i(ph1_exp), .ph2_exp_i(ph2_exp),
    .rdata_o, .ctrl_o(ctrl), .start_o(start), .stop_o(stop), .kick_o(kick), .irq_o
  );

  wdt_prescaler #(.BASE_LOG2(BASE_LOG2), .PS_W(PS_W)) u_pres (
    .clk_i, .rst_ni, .run_i(run), .clr_i(clr), .ps_i(ctrl.ps), .tick_o(tick)
  );

  wdt_phase_ctrl #(.PW(PHASE_W)) u_phase (
    .clk_i, .rst_ni, .tick_i(tick), .start_i(start), .stop_i(stop), .kick_i(kick),
    .p1_i(ctrl.p1), .p2_i(ctrl.p2), .mode_i(ctrl.mode),
    .run_o(run), .clr_o(clr), .ph1_exp_o(ph1_exp), .ph2_exp_o(ph2_exp), .rst_o(rst_vec)
  );

  assign rst_chip_o = rst_vec[0];
  assign rst_cpu_o  = rst_vec[1];
  assign rst_sw_o   = rst_vec[2];
endmodule

// File: tb/tb_two_phase_wdt.sv
module tb_two_phase_wdt;
  localparam int BASE = 2;
  localparam int T0   = 1 << BASE;

  logic clk = 0, rst_n = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic we = 0, re = 0, irq, r_chip, r_cpu, r_sw;
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  typedef struct {int at; int kind; string req;} exp_t;
  exp_t q[$];
  logic irq_prev = 0;

  two_phase_wdt #(.ADDR_W(4), .BASE_LOG2(BASE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
    .rdata_o(rdata), .irq_o(irq), .rst_chip_o(r_chip), .rst_cpu_o(r_cpu), .rst_sw_o(r_sw)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic string kname(int k);
    case (k) 1: return "irq"; 2: return "chip"; 3: return "cpu"; 4: return "sw"; default: return "?"; endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_ev(int at, int kind, string req);
    q.push_back('{at, kind, req});
  endtask

  task automatic match(int k);
    exp_t e;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL R6: actual unexpected %s at cycle %0d expected none", kname(k), cyc);
    end else begin
      e = q.pop_front();
      if (e.at != cyc || e.kind != k) begin
        errors++;
        $display("FAIL %s: actual %s at cycle %0d expected %s at cycle %0d",
                 e.req, kname(k), cyc, kname(e.kind), e.at);
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (({r_chip, r_cpu, r_sw} & ({r_chip, r_cpu, r_sw} - 3'd1)) != 0) begin
        checks++; errors++;
        $display("FAIL R5: actual %b expected one-hot", {r_chip, r_cpu, r_sw});
      end
      if (irq && !irq_prev) match(1);
      if (r_chip) match(2);
      if (r_cpu)  match(3);
      if (r_sw)   match(4);
      if (q.size() > 0 && q[0].at < cyc) begin
        checks++; errors++;
        $display("FAIL %s: actual no %s by cycle %0d expected at cycle %0d",
                 q[0].req, kname(q[0].kind), cyc, q[0].at);
        void'(q.pop_front());
      end
      irq_prev = irq;
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d, output int e);
    @(negedge clk);
    addr = a; wdata = d; we = 1; e = cyc + 1;
    @(negedge clk);
    we = 0; wdata = '0;
  endtask

  task automatic rd_chk(logic [3:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    addr = a; re = 1;
    @(negedge clk);
    re = 0;
    chk(req, rdata, exp);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(bit en, int ps, int p1, int p2, int mode);
    return (32'(en) << 31) | (32'(ps) << 29) | (32'(p1) << 22) | (32'(p2) << 15) | 32'(mode);
  endfunction

  initial begin
    int e, k, tmp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1, R11
    chk("R1 irq", 32'(irq), 0);
    chk("R1 resets", 32'({r_chip, r_cpu, r_sw}), 0);
    rd_chk(4'h8, 32'h0000_0001, "R1 ctrl");
    rd_chk(4'h4, 32'h0, "R1 status");
    rd_chk(4'h0, 32'h0, "R11 kick reads zero");

    // R3 R4 R5 basic cpu reset
    wr(4'h8, mk(1, 0, 2, 1, 1), e);
    expect_ev(e + T0 * 3, 1, "R3");
    expect_ev(e + T0 * 5, 3, "R4");
    drain();
    rd_chk(4'h4, 32'hC000_0000, "R4 status");
    rd_chk(4'h8, mk(0, 0, 2, 1, 1), "R6 ctrl kept, enable cleared");
    // R10
    wr(4'h4, 32'h4000_0000, tmp);
    chk("R10 irq stays", 32'(irq), 1);
    rd_chk(4'h4, 32'h8000_0000, "R10 clear bit30 only");
    wr(4'h4, 32'h0, tmp);
    rd_chk(4'h4, 32'h8000_0000, "R10 zero write");
    wr(4'h4, 32'h8000_0000, tmp);
    chk("R10 irq drops", 32'(irq), 0);
    rd_chk(4'h4, 32'h0, "R10 cleared");
    repeat (40) @(negedge clk);  // R6 quiet

    // R2 prescale 2, chip mode 0
    wr(4'h8, mk(1, 2, 0, 0, 0), e);
    expect_ev(e + T0 * 4, 1, "R2");
    expect_ev(e + T0 * 8, 2, "R5 mode0");
    drain();
    wr(4'h4, 32'hC000_0000, tmp);

    // R5 mode 2 with prescale 1
    wr(4'h8, mk(1, 1, 1, 2, 2), e);
    expect_ev(e + 2 * T0 * 2, 1, "R2");
    expect_ev(e + 2 * T0 * 5, 4, "R5 mode2");
    drain();
    wr(4'h4, 32'hC000_0000, tmp);

    // R5 mode 3
    wr(4'h8, mk(1, 0, 0, 0, 3), e);
    expect_ev(e + T0, 1, "R3");
    expect_ev(e + 2 * T0, 2, "R5 mode3");
    drain();
    wr(4'h4, 32'hC000_0000, tmp);

    // R7 kick
    wr(4'h8, mk(1, 0, 3, 0, 1), e);
    repeat (2) @(negedge clk);
    wr(4'h0, 32'h7FFF_FFFF, tmp);
    repeat (4) @(negedge clk);
    wr(4'h0, 32'h8000_0000, k);
    expect_ev(k + T0 * 4, 1, "R7 kick restart");
    expect_ev(k + T0 * 5, 3, "R7 kick restart");
    drain();
    wr(4'h4, 32'hC000_0000, tmp);
    wr(4'h0, 32'h8000_0000, tmp);
    repeat (60) @(negedge clk);
    rd_chk(4'h4, 32'h0, "R7 kick while idle");
    rd_chk(4'h8, mk(0, 0, 3, 0, 1), "R7 kick while idle ctrl");

    // R8 disable and restart
    wr(4'h8, mk(1, 0, 2, 0, 1), e);
    repeat (3) @(negedge clk);
    wr(4'h8, mk(0, 0, 2, 0, 1), tmp);
    repeat (40) @(negedge clk);
    rd_chk(4'h4, 32'h0, "R8 stopped");
    wr(4'h8, mk(1, 0, 2, 0, 1), e);
    expect_ev(e + T0 * 3, 1, "R8 fresh start");
    expect_ev(e + T0 * 4, 3, "R8 fresh start");
    drain();
    wr(4'h4, 32'hC000_0000, tmp);

    // R9 lock-out
    wr(4'h8, mk(1, 0, 0, 3, 0), e);
    expect_ev(e + T0, 1, "R9");
    expect_ev(e + T0 * 5, 2, "R9 reset unavoidable");
    while (cyc < e + T0 + 2) @(negedge clk);
    wr(4'h8, mk(0, 0, 0, 3, 0), tmp);
    wr(4'h0, 32'h8000_0000, tmp);
    drain();
    rd_chk(4'h4, 32'hC000_0000, "R9 status");
    repeat (40) @(negedge clk);

    done = 1;
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R4: actual %0d pending events expected 0", q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule